// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block paces a run of analog-to-digital conversions on behalf of an external converter. Each conversion lasts a fixed number of conversion-clock periods. The conversion clock is a programmable division of the system clock. At the start of every conversion the controller emits a one-cycle start strobe and the channel number to sample. When the last conversion of a run finishes, it raises a completion flag. A run holds one, four or eight conversions over consecutive channels, starting from a programmable first channel. The run happens once, or repeats for as long as scan mode is on.

Software programs two control bytes. The timing byte holds the clock divisor. The mode byte holds the first channel, the length selects and the scan enable. A write to either byte, or to both in the same cycle, always cancels whatever is in progress and starts a fresh run. This holds in every cycle, including the final conversion-clock period of a run. In that cycle the write takes priority over end-of-run handling, so the restart is never dropped.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `conv_start`, `seq_busy` and `seq_done` are all 0, and no conversion begins until a control write occurs.
- R2: A write to the timing byte alone (`wr_a`) or to the mode byte alone (`wr_b`) starts a run. In the next cycle `conv_start`=1, `seq_busy`=1, `seq_done`=0, and `conv_ch` equals the first-channel field of the mode byte as it stands after the write.
- R3: When both bytes are written in the same cycle, the run restarts exactly once, and that `conv_start` pulse lasts a single cycle.
- R4: The conversion clock ticks once every `a_data`+1 system clocks. Each conversion takes CONV_TICKS (default 10) ticks, so consecutive `conv_start` pulses are 10·(`a_data`+1) cycles apart.
- R5: Run length is set by the mode byte. Bit 4 set gives 1 conversion. Otherwise bit 3 set gives 8 conversions and bit 3 clear gives 4.
- R6: The channel starts at mode bits [2:0] and increases by one per conversion, wrapping from 7 to 0.
- R7: With scan off (mode bit 5 = 0), `seq_done` rises and `seq_busy` falls in the cycle after the final conversion ends, that is N·10·(`a_data`+1) cycles after the first `conv_start` of a run of N conversions.
- R8: With scan on (mode bit 5 = 1), a new run starts from the first channel as soon as a run ends. `seq_busy` stays 1 and `seq_done` stays 1 after the first completion.
- R9: A write while a run is active, or after it has completed, clears the conversion counter and `seq_done` and begins a new run from its first conversion.
- R10: A write sampled in the final conversion-clock cycle of a run still starts a new run: `conv_start`=1 and `seq_done`=0 in the next cycle.
- R11: Two single-byte writes on consecutive cycles produce two restarts, giving `conv_start` pulses in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_a | input | 1 | Write strobe for the timing byte |
| wr_b | input | 1 | Write strobe for the mode byte |
| a_data | input | DIV_W (4) | Timing byte value: conversion-clock divisor minus one |
| b_data | input | 6 | Mode byte value: [2:0] first channel, [3] eight-long, [4] single, [5] scan |
| conv_start | output | 1 | One-cycle strobe at the start of each conversion |
| conv_ch | output | 3 | Channel of the current conversion |
| seq_busy | output | 1 | A run is in progress |
| seq_done | output | 1 | Run-complete flag |

## Verification
The assertions assume that each write strobe is high for whole cycles only and that its data is valid in the same cycle. They also assume CONV_TICKS is at least 2, so start strobes can never be adjacent unless a write caused them. The bench changes the strobes and data only at the falling clock edge and holds each strobe for exactly one cycle. Divisors are kept small so that many runs fit in the time available. Restarts are placed at random points, at the final tick edge and on back-to-back cycles, so the write-priority path is exercised where it matters most.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CH_W   = 3;
    localparam int IDX_W  = 3;

    typedef struct packed {
        logic            scan;
        logic            single;
        logic            eight;
        logic [CH_W-1:0] first_ch;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic logic [IDX_W-1:0] last_index(input mode_t m);
        if (m.single)
            return IDX_W'(0);
        else if (m.eight)
            return IDX_W'(7);
        else
            return IDX_W'(3);
    endfunction
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_a,
    input  logic             wr_b,
    input  logic [DIV_W-1:0] a_data,
    input  logic [MODE_W-1:0] b_data,
    output logic [DIV_W-1:0] div,
    output mode_t            mode,
    output logic [CH_W-1:0]  first_nxt,
    output logic             restart
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        mode_t            mode;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_a)
            regs_d.div = a_data;
        if (wr_b)
            regs_d.mode = mode_t'(b_data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    assign div       = regs_q.div;
    assign mode      = regs_q.mode;
    assign first_nxt = regs_d.mode.first_ch;
    assign restart   = wr_a | wr_b;

    // R2
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_a |=> $stable(div));
endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] pc;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr || !run)
            st_d.pc = '0;
        else if (st_q.pc == div)
            st_d.pc = '0;
        else
            st_d.pc = st_q.pc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign tick = run && !clr && (st_q.pc == div);

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CONV_TICKS = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [CH_W-1:0] first_nxt,
    input  mode_t           mode,
    input  logic            tick,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_ch,
    output logic            busy,
    output logic            done
);
    localparam int CT_W = $clog2(CONV_TICKS + 1);
    localparam logic [CT_W-1:0] CT_LAST = CT_W'(CONV_TICKS - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             start;
        logic [CT_W-1:0]  ct;
        logic [IDX_W-1:0] idx;
        logic [CH_W-1:0]  ch;
    } seq_t;

    seq_t s_d, s_q;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = last_index(mode);

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (restart) begin
            // a write wins over every other event, including the final tick
            s_d.busy  = 1'b1;
            s_d.done  = 1'b0;
            s_d.ct    = '0;
            s_d.idx   = '0;
            s_d.ch    = first_nxt;
            s_d.start = 1'b1;
        end else if (s_q.busy && tick) begin
            if (s_q.ct == CT_LAST) begin
                s_d.ct = '0;
                if (s_q.idx == last_idx) begin
                    s_d.done = 1'b1;
                    s_d.idx  = '0;
                    s_d.ch   = mode.first_ch;
                    if (mode.scan)
                        s_d.start = 1'b1;
                    else
                        s_d.busy = 1'b0;
                end else begin
                    s_d.idx   = s_q.idx + 1'b1;
                    s_d.ch    = s_q.ch + 1'b1;
                    s_d.start = 1'b1;
                end
            end else begin
                s_d.ct = s_q.ct + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign conv_start = s_q.start;
    assign conv_ch    = s_q.ch;
    assign busy       = s_q.busy;
    assign done       = s_q.done;

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (conv_start && busy && !done));

    // R9
    abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && done) |=> !done);

    // R6
    first_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (conv_ch == $past(first_nxt)));

    // R3
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !restart) |=> !conv_start);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx <= last_idx);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DIV_W      = 4,
    parameter int CONV_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DIV_W-1:0]  a_data,
    input  logic [MODE_W-1:0] b_data,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch,
    output logic              seq_busy,
    output logic              seq_done
);
    logic [DIV_W-1:0] div;
    mode_t            mode;
    logic [CH_W-1:0]  first_nxt;
    logic             restart;
    logic             tick;

    adc_ctrl_regs #(.DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_a      (wr_a),
        .wr_b      (wr_b),
        .a_data    (a_data),
        .b_data    (b_data),
        .div       (div),
        .mode      (mode),
        .first_nxt (first_nxt),
        .restart   (restart)
    );

    adc_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (seq_busy),
        .clr   (restart),
        .div   (div),
        .tick  (tick)
    );

    adc_seq_fsm #(.CONV_TICKS(CONV_TICKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .first_nxt  (first_nxt),
        .mode       (mode),
        .tick       (tick),
        .conv_start (conv_start),
        .conv_ch    (conv_ch),
        .busy       (seq_busy),
        .done       (seq_done)
    );

    // R1
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && !restart) |=> !conv_start);
endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_a = 1'b0;
    logic       wr_b = 1'b0;
    logic [3:0] a_data = '0;
    logic [5:0] b_data = '0;
    logic       conv_start;
    logic [2:0] conv_ch;
    logic       seq_busy;
    logic       seq_done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [3:0] a_s = '0;
    logic [5:0] b_s = '0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b),
        .a_data(a_data), .b_data(b_data), .conv_start(conv_start),
        .conv_ch(conv_ch), .seq_busy(seq_busy), .seq_done(seq_done)
    );

    function automatic int seq_len(input logic [5:0] b);
        if (b[4]) return 1;
        return b[3] ? 8 : 4;
    endfunction

    function automatic int period(input logic [3:0] a);
        return 10 * (int'(a) + 1);
    endfunction

    function automatic bit exp_start(input int j);
        int p = period(a_s);
        int n = seq_len(b_s);
        return (j % p == 0) && (b_s[5] || (j / p) < n);
    endfunction

    function automatic int exp_ch(input int j);
        int m = (j / period(a_s)) % seq_len(b_s);
        return (int'(b_s[2:0]) + m) % 8;
    endfunction

    function automatic bit exp_done(input int j);
        return j >= seq_len(b_s) * period(a_s);
    endfunction

    function automatic bit exp_busy(input int j);
        return b_s[5] || (j < seq_len(b_s) * period(a_s));
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input bit lo, input bit hi, input logic [3:0] a, input logic [5:0] b);
        wr_a = lo; wr_b = hi; a_data = a; b_data = b;
        if (lo) a_s = a;
        if (hi) b_s = b;
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0;
    endtask

    // compare samples j = 0 .. ncyc-1 after a write; ends at sample ncyc-1
    task automatic run_seq(input int ncyc, input string req);
        int bs = -1, bd = -1;
        int s_act = 0, s_exp = 0, d_act = 0, d_exp = 0;
        for (int j = 0; j < ncyc; j++) begin
            bit es, ed, eb;
            int ec;
            if (j > 0) @(negedge clk);
            es = exp_start(j);
            ec = es ? exp_ch(j) : int'(conv_ch);
            ed = exp_done(j);
            eb = exp_busy(j);
            if (bs < 0 && (conv_start !== es || int'(conv_ch) != ec)) begin
                bs = j; s_act = {conv_start, conv_ch}; s_exp = {es, 3'(ec)};
            end
            if (bd < 0 && (seq_done !== ed || seq_busy !== eb)) begin
                bd = j; d_act = {seq_done, seq_busy}; d_exp = {ed, eb};
            end
        end
        chk(bs < 0, req, $sformatf("start/channel {start,ch} at cycle %0d", bs), s_act, s_exp);
        chk(bd < 0, req, $sformatf("done/busy {done,busy} at cycle %0d", bd), d_act, d_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int full;
        void'($urandom(32'd7531));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: idle after reset
        chk(conv_start == 1'b0, "R1", "conv_start", int'(conv_start), 0);
        chk(seq_busy == 1'b0, "R1", "seq_busy", int'(seq_busy), 0);
        chk(seq_done == 1'b0, "R1", "seq_done", int'(seq_done), 0);

        // R3 word write, R4 R5 R6 R7 four-long run from channel 5
        wr(1'b1, 1'b1, 4'd0, 6'b000_101);
        run_seq(seq_len(b_s) * period(a_s) + 20, "R3/R7");

        // R2 timing byte alone keeps mode, R4 divisor 2
        wr(1'b1, 1'b0, 4'd2, 6'b0);
        run_seq(seq_len(b_s) * period(a_s) + 5, "R2/R4");

        // R5 single conversion
        wr(1'b0, 1'b1, 4'd0, 6'b010_011);
        run_seq(period(a_s) + 8, "R5");

        // R6 eight-long run wrapping from channel 6
        wr(1'b0, 1'b1, 4'd1, 6'b001_110);
        run_seq(seq_len(b_s) * period(a_s) + 4, "R6");

        // R9 abort mid-run
        wr(1'b0, 1'b1, 4'd0, 6'b000_010);
        run_seq(25, "R9");
        wr(1'b1, 1'b0, 4'd1, 6'b0);
        run_seq(seq_len(b_s) * period(a_s) + 3, "R9");

        // R10 write sampled at the final tick edge
        wr(1'b1, 1'b1, 4'd0, 6'b000_001);
        run_seq(seq_len(b_s) * period(a_s), "R10");
        wr(1'b0, 1'b1, 4'd0, 6'b010_100);
        chk(conv_start == 1'b1 && seq_done == 1'b0, "R10", "restart at last tick {start,done}",
            {conv_start, seq_done}, 2);
        run_seq(period(a_s) + 4, "R10");

        // R11 back-to-back byte writes
        wr(1'b1, 1'b0, 4'd0, 6'b0);
        chk(conv_start == 1'b1, "R11", "first byte restart", int'(conv_start), 1);
        wr(1'b0, 1'b1, 4'd0, 6'b000_011);
        chk(conv_start == 1'b1 && conv_ch == 3'd3, "R11", "second byte restart {start,ch}",
            {conv_start, conv_ch}, {1'b1, 3'd3});
        run_seq(seq_len(b_s) * period(a_s) + 3, "R11");

        // R8 scan repeats
        wr(1'b0, 1'b1, 4'd0, 6'b100_110);
        run_seq(2 * seq_len(b_s) * period(a_s) + 5, "R8");
        wr(1'b0, 1'b1, 4'd0, 6'b110_000);
        run_seq(3 * period(a_s) + 2, "R8");

        // random restarts at arbitrary points (R9)
        for (int it = 0; it < 14; it++) begin
            logic [3:0] ra = 4'($urandom_range(0, 3));
            logic [5:0] rb = 6'($urandom_range(0, 31));
            int sel = $urandom_range(0, 2);
            wr(sel != 1, sel != 0, ra, rb);
            full = seq_len(b_s) * period(a_s);
            run_seq($urandom_range(1, full + 8), "R9");
        end
        wr(1'b1, 1'b1, 4'd0, 6'b001_000);
        run_seq(seq_len(b_s) * period(a_s) + 5, "R7");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule